// File: doc/BRIEF.md
# PHY address discovery scanner

This block locates a PHY on a shared management bus. It sits above an MDIO management controller and drives that controller's read requests. When it is started, it first probes a preferred address if one is offered. If that probe fails, or if no preferred address is offered, it sweeps every address from the top of the address space down to zero. The first address whose status word looks like a real PHY ends the search.

Each probe is a read of management register 1, the status register. A status word is rejected when it is all ones, which is what an empty address returns. It is also rejected when any bit of the fixed capability mask 0x1808 is clear. Those mask bits are bit 12 (10 Mb/s full duplex), bit 11 (10 Mb/s half duplex) and bit 3 (auto-negotiation ability).

Before it issues a request, the scanner waits for the controller to report idle. It waits for idle again before it judges the returned word. If either wait runs too long, the address counts as empty and the scan moves on. The result is a found flag and an address, both held with a done flag until the next start.

Top module: `phy_addr_scanner`

## Requirements
- R1: After reset, busy, done, found and rd_req are all low and phy_addr is 0.
- R2: Each probe is one single-cycle rd_req pulse, with rd_reg equal to 1 and rd_phy equal to the candidate address. Two consecutive cycles never both carry a request.
- R3: A request is issued only in a cycle where mgmt_idle is high. The returned word is judged only once mgmt_idle has gone high again after the request.
- R4: A status word of 0xFFFF is never accepted, even though it contains every mask bit.
- R5: A status word is accepted only when bits 12, 11 and 3 (mask 0x1808) are all set. The other bits do not matter.
- R6: With pref_valid high at start, pref_addr is probed first. If it is accepted, the search ends after that single read.
- R7: If the preferred probe fails, or pref_valid is low, addresses are probed from 31 down to 0. The first accepted address is reported in phy_addr with found high.
- R8: Suppose mgmt_idle stays low for IDLE_TIMEOUT consecutive cycles while the scanner waits, either before a request or after one. The current address is then treated as empty and the scan continues.
- R9: If every probe fails, done rises with found low. That takes 32 reads without a preferred address and 33 with one.
- R10: A start pulse while busy has no effect on the sequence of reads or on the result. A start pulse while idle or done begins a fresh search.
- R11: done and busy are never high together, and found is high only while done is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a search when the scanner is not busy |
| pref_valid | input | 1 | A preferred address is offered |
| pref_addr | input | ADDR_W | Preferred address |
| mgmt_idle | input | 1 | Management controller is ready or has finished |
| rd_data | input | DATA_W | Word read back by the controller |
| rd_req | output | 1 | Read request pulse to the controller |
| rd_phy | output | ADDR_W | PHY address of the request |
| rd_reg | output | ADDR_W | Register number of the request (always 1) |
| busy | output | 1 | Search in progress |
| done | output | 1 | Search finished, held until the next start |
| found | output | 1 | A PHY was accepted |
| phy_addr | output | ADDR_W | Accepted address, 0 when none |

## Verification
The assertions rely on the controller accepting a request only while it reports idle. They also rely on it dropping mgmt_idle in the cycle after it accepts the request, and on rd_data being valid once idle returns. The bench's controller model follows exactly that contract: it uses a fixed three-cycle busy window, or a longer one for a single deliberately stuck address. That stuck window runs past the timeout but ends before the next probe's wait would also expire. Inputs change only on the falling clock edge. The sweep places one valid PHY at each of the 32 addresses, both with and without it as the preferred address.

// File: rtl/phy_scan_pkg.sv
// Shared definitions for the PHY address scanner.
// Assumes a 5-bit management address space and a 16-bit register width.
package phy_scan_pkg;
    typedef enum logic [1:0] {
        SC_IDLE = 2'd0,
        SC_PRE  = 2'd1,
        SC_POST = 2'd2,
        SC_DONE = 2'd3
    } scan_state_t;

    localparam logic [4:0] STATUS_REG_NUM = 5'd1;
endpackage

// File: rtl/scan_idle_timer.sv
// Counts consecutive cycles spent waiting for the management port.
// Assumes 'run' is high only while a wait is in progress.
// 'expire' pulses in the LIMIT-th consecutive waiting cycle.
module scan_idle_timer #(
    parameter int LIMIT = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic expire
);
    localparam int CW = $clog2(LIMIT + 1);

    logic [CW-1:0] cnt;

    assign expire = run && (cnt == CW'(LIMIT - 1));

    // Advance while waiting; restart on any break or on expiry.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (!run || expire)
            cnt <= '0;
        else
            cnt <= cnt + 1'b1;
    end

    // R8
    timer_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt < CW'(LIMIT));
endmodule

// File: rtl/scan_candidate_check.sv
// Decides whether a status word could come from a present PHY.
// It rejects the all-ones word and any word missing a capability bit.
module scan_candidate_check #(
    parameter int          DATA_W     = 16,
    parameter logic [15:0] NEED_MASK  = 16'h1808,
    parameter logic [15:0] EMPTY_WORD = 16'hFFFF
) (
    input  logic [DATA_W-1:0] word,
    output logic              ok
);
    localparam logic [DATA_W-1:0] MASK_W  = DATA_W'(NEED_MASK);
    localparam logic [DATA_W-1:0] EMPTY_W = DATA_W'(EMPTY_WORD);

    // Acceptance test: not empty and every capability bit present.
    always_comb ok = (word != EMPTY_W) && ((word & MASK_W) == MASK_W);
endmodule

// File: rtl/phy_addr_scanner.sv
// Sequencer that finds a PHY by reading status registers through a
// management controller. It tries the preferred address first, then
// sweeps from the highest address downward.
// Assumes the controller takes rd_req only while mgmt_idle is high and
// drops mgmt_idle in the following cycle.
module phy_addr_scanner #(
    parameter int          ADDR_W       = 5,
    parameter int          DATA_W       = 16,
    parameter int          IDLE_TIMEOUT = 64,
    parameter logic [15:0] NEED_MASK    = 16'h1808
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              pref_valid,
    input  logic [ADDR_W-1:0] pref_addr,
    input  logic              mgmt_idle,
    input  logic [DATA_W-1:0] rd_data,
    output logic              rd_req,
    output logic [ADDR_W-1:0] rd_phy,
    output logic [ADDR_W-1:0] rd_reg,
    output logic              busy,
    output logic              done,
    output logic              found,
    output logic [ADDR_W-1:0] phy_addr
);
    import phy_scan_pkg::*;

    localparam logic [ADDR_W-1:0] TOP_ADDR = '1;

    scan_state_t       state;
    logic [ADDR_W-1:0] cur_addr;
    logic              pref_phase;
    logic              found_q;
    logic [ADDR_W-1:0] addr_q;
    logic              word_ok;
    logic              expire;
    logic              waiting;
    logic              start_ok;
    logic              probe_pass;
    logic              probe_fail;

    scan_candidate_check #(
        .DATA_W    (DATA_W),
        .NEED_MASK (NEED_MASK),
        .EMPTY_WORD(16'hFFFF)
    ) u_check (
        .word(rd_data),
        .ok  (word_ok)
    );

    scan_idle_timer #(
        .LIMIT(IDLE_TIMEOUT)
    ) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (waiting),
        .expire(expire)
    );

    // Decode waits, probe outcomes and request strobes from the state.
    always_comb begin
        waiting    = ((state == SC_PRE) || (state == SC_POST)) && !mgmt_idle;
        start_ok   = start && ((state == SC_IDLE) || (state == SC_DONE));
        probe_pass = (state == SC_POST) && mgmt_idle && word_ok;
        probe_fail = ((state == SC_POST) && mgmt_idle && !word_ok) ||
                     (((state == SC_PRE) || (state == SC_POST)) && expire);
        rd_req     = (state == SC_PRE) && mgmt_idle;
    end

    // Main sequencer: start, probe, advance to next candidate or finish.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= SC_IDLE;
            cur_addr   <= '0;
            pref_phase <= 1'b0;
            found_q    <= 1'b0;
            addr_q     <= '0;
        end else if (start_ok) begin
            state      <= SC_PRE;
            cur_addr   <= pref_valid ? pref_addr : TOP_ADDR;
            pref_phase <= pref_valid;
            found_q    <= 1'b0;
            addr_q     <= '0;
        end else if (probe_pass) begin
            state   <= SC_DONE;
            found_q <= 1'b1;
            addr_q  <= cur_addr;
        end else if (probe_fail) begin
            if (pref_phase) begin
                pref_phase <= 1'b0;
                cur_addr   <= TOP_ADDR;
                state      <= SC_PRE;
            end else if (cur_addr == '0) begin
                state <= SC_DONE;
            end else begin
                cur_addr <= cur_addr - 1'b1;
                state    <= SC_PRE;
            end
        end else if (rd_req) begin
            state <= SC_POST;
        end
    end

    assign rd_phy   = cur_addr;
    assign rd_reg   = ADDR_W'(STATUS_REG_NUM);
    assign busy     = (state == SC_PRE) || (state == SC_POST);
    assign done     = (state == SC_DONE);
    assign found    = found_q;
    assign phy_addr = addr_q;

    // R2
    req_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |=> !rd_req);

    // R4 R5
    accept_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(found) |-> ($past(rd_data) != DATA_W'(16'hFFFF)) &&
                         (($past(rd_data) & DATA_W'(NEED_MASK)) == DATA_W'(NEED_MASK)));

    // R10
    busy_ignore_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start) |=> (busy || done));

    // R11
    flags_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy && done) && (!found || done));
endmodule

// File: tb/sim_phy_addr_scanner.sv
module sim_phy_addr_scanner;
    localparam int CLK_PERIOD = 10;
    localparam int TMO        = 20;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        pref_valid = 1'b0;
    logic [4:0]  pref_addr = '0;
    logic        mgmt_idle;
    logic [15:0] rd_data;
    logic        rd_req;
    logic [4:0]  rd_phy, rd_reg, phy_addr;
    logic        busy, done, found;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    logic [15:0] resp [32];
    logic        stuck_en = 1'b0;
    logic [4:0]  stuck_a = '0;

    int exp_seq [64];
    int exp_n;
    int n_reads = 0;
    int bad_order = 0;
    int bad_reg = 0;
    int bad_idle = 0;

    int          ctl_cnt;
    logic [4:0]  ctl_addr;

    always #(CLK_PERIOD/2) clk = ~clk;

    phy_addr_scanner #(.IDLE_TIMEOUT(TMO)) u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .pref_valid(pref_valid),
        .pref_addr(pref_addr), .mgmt_idle(mgmt_idle), .rd_data(rd_data),
        .rd_req(rd_req), .rd_phy(rd_phy), .rd_reg(rd_reg), .busy(busy),
        .done(done), .found(found), .phy_addr(phy_addr)
    );

    // Management controller model: three busy cycles, longer for the stuck address.
    always @(posedge clk) begin
        if (!rst_n) begin
            mgmt_idle <= 1'b1;
            rd_data   <= 16'h0000;
            ctl_cnt   <= 0;
            ctl_addr  <= '0;
        end else if (mgmt_idle && rd_req) begin
            mgmt_idle <= 1'b0;
            ctl_addr  <= rd_phy;
            ctl_cnt   <= (stuck_en && rd_phy == stuck_a) ? TMO + 6 : 3;
        end else if (!mgmt_idle) begin
            if (ctl_cnt <= 1) begin
                mgmt_idle <= 1'b1;
                rd_data   <= resp[ctl_addr];
            end
            ctl_cnt <= ctl_cnt - 1;
        end
    end

    // Request monitor: order, register number and idle handshake.
    always @(posedge clk) begin
        if (rst_n && rd_req) begin
            if (n_reads < 64 && int'(rd_phy) != exp_seq[n_reads]) bad_order++;
            if (rd_reg != 5'd1) bad_reg++;
            if (!mgmt_idle) bad_idle++;
            n_reads++;
        end
    end

    // Watchdog.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            errors++;
            $display("FAIL watchdog: actual %0d cycles expected < 150000", cycles);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic chk(input string req, input int act, input int expv);
        checks++;
        if (act != expv) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, expv);
        end
    endtask

    function automatic bit good(input int a);
        if (stuck_en && a == int'(stuck_a)) return 1'b0;
        return (resp[a] != 16'hFFFF) && ((resp[a] & 16'h1808) == 16'h1808);
    endfunction

    task automatic all_empty();
        for (int i = 0; i < 32; i++) resp[i] = 16'hFFFF;
    endtask

    task automatic wait_done();
        int t = 0;
        while (!done && t < 5000) begin
            @(negedge clk);
            t++;
        end
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL R7: actual done 0 expected 1");
        end
    endtask

    // Run one search, optionally pulsing start mid-scan, and check it.
    task automatic run(input string tag, input bit pv, input int pa, input bit poke);
        int ef = 0;
        int ea = 0;
        exp_n = 0;
        if (pv) begin
            exp_seq[exp_n++] = pa;
            if (good(pa)) begin ef = 1; ea = pa; end
        end
        if (ef == 0) begin
            for (int a = 31; a >= 0; a--) begin
                exp_seq[exp_n++] = a;
                if (good(a)) begin ef = 1; ea = a; break; end
            end
        end
        @(negedge clk);
        n_reads = 0; bad_order = 0; bad_reg = 0; bad_idle = 0;
        pref_valid = pv; pref_addr = 5'(pa); start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk({tag, " R10 busy after start"}, int'(busy), 1);
        if (poke) begin
            repeat (7) @(negedge clk);
            pref_valid = 1'b1; pref_addr = 5'd0; start = 1'b1;
            @(negedge clk);
            start = 1'b0; pref_valid = pv; pref_addr = 5'(pa);
        end
        wait_done();
        chk({tag, " R7 found"}, int'(found), ef);
        chk({tag, " R7 phy_addr"}, int'(phy_addr), ea);
        chk({tag, " R9 read count"}, n_reads, exp_n);
        chk({tag, " R6 read order"}, bad_order, 0);
        chk({tag, " R2 register number"}, bad_reg, 0);
        chk({tag, " R3 idle before request"}, bad_idle, 0);
        chk({tag, " R11 busy low at done"}, int'(busy), 0);
    endtask

    initial begin
        all_empty();
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 busy", int'(busy), 0);
        chk("R1 done", int'(done), 0);
        chk("R1 found", int'(found), 0);
        chk("R1 rd_req", int'(rd_req), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 phy_addr", int'(phy_addr), 0);

        // R7 single PHY, no preference
        all_empty(); resp[5] = 16'h7849;
        run("R7 scan", 1'b0, 0, 1'b0);
        // R6 preferred passes although a higher one exists
        resp[20] = 16'h1808; resp[12] = 16'h796D;
        run("R6 pref hit", 1'b1, 12, 1'b0);
        // R6 preferred empty, scan finds 20
        resp[12] = 16'hFFFF;
        run("R6 pref miss", 1'b1, 12, 1'b0);
        // R9 nothing present, with and without preference
        all_empty();
        run("R9 none", 1'b0, 0, 1'b0);
        run("R9 none pref", 1'b1, 7, 1'b0);
        // R4 R5 all-ones, one missing bit each, then a full mask
        all_empty();
        resp[30] = 16'h1800; resp[29] = 16'h1008; resp[28] = 16'h0808;
        resp[27] = 16'hFFFF; resp[26] = 16'h1808;
        run("R5 mask bits", 1'b0, 0, 1'b0);
        run("R4 pref all-ones", 1'b1, 27, 1'b0);
        // R8 stuck controller at a valid address is skipped
        all_empty(); resp[31] = 16'h1808; resp[10] = 16'h1808;
        stuck_en = 1'b1; stuck_a = 5'd31;
        run("R8 stuck", 1'b0, 0, 1'b0);
        stuck_a = 5'd10;
        run("R8 stuck pref", 1'b1, 10, 1'b0);
        stuck_en = 1'b0;
        // R10 start while busy is ignored
        all_empty(); resp[3] = 16'h1808;
        run("R10 poke", 1'b0, 0, 1'b1);
        // R10 start from done restarts
        run("R10 rerun", 1'b1, 3, 1'b0);
        // Sweep: one PHY at every address, scanned and preferred
        for (int a = 0; a < 32; a++) begin
            all_empty(); resp[a] = 16'h1808 | 16'(a);
            run("R7 sweep", 1'b0, 0, 1'b0);
            run("R6 sweep", 1'b1, a, 1'b0);
        end
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule